// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a general-purpose interval timer with a small register port. A 16-bit up-counter advances once every (prescale + 1) ticks of a selected source clock. The source can be the system clock or the system clock divided by sixteen. When the counter sits on the reference value and the next count tick arrives, the counter returns to zero and a reference event flag is latched. The interrupt line is high while that flag is pending and the interrupt-enable bit is set.

Software programs the timer with four registers: mode, reference, counter and event. The event register is cleared by writing a one to its bit. The enable bit of the mode register works as an active-low soft reset. Turning it off returns the reference, counter and event state to zero. Any write to the mode or reference register restarts the prescaler phase, so that new settings take effect from a known point.

Top module: `prt_timer`

## Requirements
- R1: After reset the mode, reference, counter and event registers read zero and `irq` is low.
- R2: Mode bit 0 is enable, bits [2:1] select the source, bit 3 is restart-on-reference, bit 4 is interrupt enable, and bits [15:8] hold the prescale value P. With source 1 (system clock), the counter advances once every P+1 clocks. The first advance comes P+1 clocks after the mode write.
- R3: With source 2, the source ticks once every 16 clocks, so the counter advances once every 16*(P+1) clocks.
- R4: With source 0 or 3, or with the restart bit clear, the counter does not move.
- R5: While enable is 0 the counter does not move. A mode write that changes enable from 1 to 0 clears the reference, counter and event registers, and the mode register takes the written value. A mode write while enable is already 0 leaves the other registers unchanged.
- R6: On a count tick with the counter equal to the reference, the counter becomes 0 and event bit 1 is set. On any other tick the counter increments.
- R7: `irq` is high exactly when mode bit 4 and event bit 1 are both set.
- R8: Writing the event register with bit 1 set clears the event. Writing it with bit 1 clear has no effect.
- R9: A counter-register write loads the value, even while the counter is running, and a counter read returns the current count.
- R10: A write to the mode or reference register restarts the prescaler phase without changing the count.
- R11: The register offsets are: mode 0x00, reference 0x04, capture 0x08 (always reads 0), counter 0x0C, and event 0x11. The event register is 8 bits wide and zero-extended on read, with bit 0 always 0. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Reference interrupt request |

## Verification
The counting path is run with prescale values 0, 3, 9 and 1 from the direct source and from the divided source. Reading the counter one clock before and at each expected advance separates an off-by-one prescale, a wrong divider ratio and a prescaler phase that is not restarted. Short reference values make the counter wrap. This shows whether the wrap happens on the reference value or one step late, and whether the event flag is set. The interrupt is checked with the enable bit off and then on. The event register is written with a zero and then with a one, to separate a write-one-to-clear from a plain write. The disable path is driven both from a running state and from an already stopped state. These two cases show whether the clear happens only on the 1-to-0 change of the enable bit.

// File: rtl/prt_pkg.sv
// Shared definitions for the prescaled reference-compare timer.
// Assumes a 16-bit mode register whose fields are fixed by the struct below.
package prt_pkg;

    // Clock source selection held in the mode register.
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_CLK  = 2'd1,
        SRC_SLOW = 2'd2,
        SRC_EXT  = 2'd3
    } clk_src_e;

    // Mode register layout, most significant field first.
    typedef struct packed {
        logic [7:0] psc;
        logic [2:0] spare;
        logic       ie;
        logic       restart;
        clk_src_e   src;
        logic       en;
    } mode_t;

    localparam int MODE_W      = $bits(mode_t);
    localparam int PSC_W       = 8;
    localparam int EVT_REF_BIT = 1;

    // Register byte offsets.
    localparam int OFS_MODE = 'h00;
    localparam int OFS_REF  = 'h04;
    localparam int OFS_CAP  = 'h08;
    localparam int OFS_CNT  = 'h0C;
    localparam int OFS_EVT  = 'h11;

endpackage

// File: rtl/prt_regs.sv
// Register file and decoder of the timer.
// Holds mode and reference. Produces the write side effects for the counter
// block and muxes read data. Assumes single-cycle write strobes and
// combinational reads with no side effects.
module prt_regs
    import prt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              evt_q,
    output mode_t             mode_q,
    output logic [DATA_W-1:0] ref_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              restart,
    output logic              clear_all,
    output logic              cnt_load,
    output logic              evt_clr
);

    logic hit_mode, hit_ref, hit_cap, hit_cnt, hit_evt;
    logic wr_mode, wr_ref;

    // Decode the byte offset into register hits.
    always_comb begin
        hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
        hit_ref  = (bus_addr == ADDR_W'(OFS_REF));
        hit_cap  = (bus_addr == ADDR_W'(OFS_CAP));
        hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
        hit_evt  = (bus_addr == ADDR_W'(OFS_EVT));
    end

    // Turn the write strobe into per-register actions.
    always_comb begin
        wr_mode   = bus_wr && hit_mode;
        wr_ref    = bus_wr && hit_ref;
        cnt_load  = bus_wr && hit_cnt;
        evt_clr   = bus_wr && hit_evt && bus_wdata[EVT_REF_BIT];
        clear_all = wr_mode && mode_q.en && !bus_wdata[0];
        restart   = wr_mode || wr_ref;
    end

    // Mode register: takes every write, including the one that disables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
        end
    end

    // Reference register: cleared by the disabling mode write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            ref_q <= '0;
        end else if (wr_ref) begin
            ref_q <= bus_wdata;
        end
    end

    // Read data mux; capture and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_mode)     bus_rdata = DATA_W'(mode_q);
        else if (hit_ref) bus_rdata = ref_q;
        else if (hit_cnt) bus_rdata = cnt_q;
        else if (hit_evt) bus_rdata = DATA_W'({evt_q, 1'b0});
        else if (hit_cap) bus_rdata = '0;
    end

endmodule

// File: rtl/prt_prescaler.sv
// Source divider and programmable prescaler of the timer.
// Emits one count tick every (psc + 1) source ticks. A source tick is either
// every clock or every SLOW_DIV clocks. The phase resets on restart and
// whenever the timer is not running.
module prt_prescaler #(
    parameter int PSC_W    = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow_sel,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             cnt_tick
);

    logic             src_tick;
    logic [PSC_W-1:0] psc_q;

    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(SLOW_DIV);
            logic [DIV_W-1:0] div_q;
            logic             div_end;

            // Mark the last clock of each slow period.
            always_comb div_end = (div_q == DIV_W'(SLOW_DIV - 1));

            // Divider phase counter, used only when the slow source is chosen.
            always_ff @(posedge clk) begin
                if (!rst_n || !run || restart || !slow_sel) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_end ? '0 : div_q + 1'b1;
                end
            end

            // Select the source tick.
            always_comb src_tick = slow_sel ? div_end : 1'b1;
        end else begin : g_nodiv
            // Without a divider, every clock is a source tick.
            always_comb src_tick = 1'b1;
        end
    endgenerate

    // Prescale phase counter, counting source ticks up to psc.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            psc_q <= '0;
        end else if (src_tick) begin
            psc_q <= (psc_q == psc) ? '0 : psc_q + 1'b1;
        end
    end

    // Count tick on the last source tick of a prescale period.
    always_comb cnt_tick = run && !restart && src_tick && (psc_q == psc);

endmodule

// File: rtl/prt_counter.sv
// Up-counter with restart on reference and the reference event flag.
// Priority: soft clear, then load, then tick. A tick is dropped in the cycle
// of a load. The event flag is set only by an applied tick that wraps.
module prt_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    input  logic [DATA_W-1:0] ref_val,
    input  logic              evt_clr,
    output logic [DATA_W-1:0] cnt_q,
    output logic              evt_q
);

    logic at_ref;
    logic wrap;

    // Detect the wrap point.
    always_comb begin
        at_ref = (cnt_q == ref_val);
        wrap   = tick && !load && at_ref;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= at_ref ? '0 : cnt_q + 1'b1;
        end
    end

    // Event flag: set on wrap, which wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            evt_q <= 1'b0;
        end else if (wrap) begin
            evt_q <= 1'b1;
        end else if (evt_clr) begin
            evt_q <= 1'b0;
        end
    end

endmodule

// File: rtl/prt_timer.sv
// Top level of the prescaled reference-compare timer.
// Connects the register file, prescaler and counter, and forms the run
// condition and the interrupt. Requires DATA_W >= 16 to hold the mode register.
module prt_timer
    import prt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int SLOW_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    mode_t             mode_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] cnt_q;
    logic              evt_q;
    logic              restart, clear_all, cnt_load, evt_clr;
    logic              run, slow_sel, cnt_tick;

    prt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .evt_q     (evt_q),
        .mode_q    (mode_q),
        .ref_q     (ref_q),
        .bus_rdata (bus_rdata),
        .restart   (restart),
        .clear_all (clear_all),
        .cnt_load  (cnt_load),
        .evt_clr   (evt_clr)
    );

    // Running needs enable, restart mode and a supported source.
    always_comb begin
        slow_sel = (mode_q.src == SRC_SLOW);
        run      = mode_q.en && mode_q.restart &&
                   ((mode_q.src == SRC_CLK) || slow_sel);
    end

    prt_prescaler #(.PSC_W(PSC_W), .SLOW_DIV(SLOW_DIV)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .slow_sel (slow_sel),
        .restart  (restart),
        .psc      (mode_q.psc),
        .cnt_tick (cnt_tick)
    );

    prt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (clear_all),
        .load      (cnt_load),
        .load_val  (bus_wdata),
        .tick      (cnt_tick),
        .ref_val   (ref_q),
        .evt_clr   (evt_clr),
        .cnt_q     (cnt_q),
        .evt_q     (evt_q)
    );

    // Interrupt request: pending event gated by the enable bit.
    always_comb irq = mode_q.ie && evt_q;

endmodule

// File: rtl/prt_timer_chk.sv
// Assertion checker for prt_timer, attached to it with bind.
module prt_timer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              irq,
    input logic [15:0]       mode_bits,
    input logic [DATA_W-1:0] ref_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              evt_q
);

    logic bad_src;
    always_comb bad_src = (mode_bits[2:1] == 2'd0) || (mode_bits[2:1] == 2'd3) || !mode_bits[3];

    // R7: the interrupt only drops as a result of a register write.
    assert_irq_drop_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));

    // R6: the event rises only when the count wrapped from the reference to zero.
    assert_evt_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> ($past(cnt_q) == $past(ref_q) && cnt_q == '0));

    // R2: without a write, the count moves only by one step or wraps to zero.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && !$stable(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

    // R5: a disabled timer holds its count.
    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bits[0] && !bus_wr) |=> $stable(cnt_q));

    // R4: an unsupported source or cleared restart bit holds the count.
    assert_hold_bad_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_src && !bus_wr) |=> $stable(cnt_q));

endmodule

bind prt_timer prt_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .irq       (irq),
    .mode_bits (16'(mode_q)),
    .ref_q     (ref_q),
    .cnt_q     (cnt_q),
    .evt_q     (evt_q)
);

// File: tb/sim_prt_timer.sv
`timescale 1ns/1ps
// Directed bench for prt_timer: one task per scenario, each checking itself.
module sim_prt_timer;

    localparam int DW = 16;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                              A_CNT = 5'h0C, A_EVT = 5'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prt_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Mode word from fields: psc[15:8], ie[4], restart[3], src[2:1], en[0].
    function automatic logic [15:0] mk(input int psc, input bit ie, input bit rs,
                                       input int src, input bit en);
        return {8'(psc), 3'b000, ie, rs, 2'(src), en};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Clear the timer, then program reference, counter and mode.
    task automatic arm(input logic [DW-1:0] r, input logic [DW-1:0] c, input logic [15:0] m);
        wr(A_MODE, 16'h0000);
        wr(A_REF, r);
        wr(A_CNT, c);
        wr(A_MODE, m);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        rd(A_MODE, v); check("R1", "mode", v, 0);
        rd(A_REF, v);  check("R1", "ref", v, 0);
        rd(A_CNT, v);  check("R1", "cnt", v, 0);
        rd(A_EVT, v);  check("R1", "evt", v, 0);
        check("R1", "irq", DW'(irq), 0);
    endtask

    task automatic t_load_stopped;
        logic [DW-1:0] v;
        wr(A_CNT, 16'h0055);
        wait_clk(10);
        rd(A_CNT, v); check("R9", "loaded count held while disabled", v, 16'h0055);
        wr(A_MODE, 16'h0000);
        rd(A_CNT, v); check("R5", "mode write with enable already 0 keeps count", v, 16'h0055);
        wr(5'h1C, 16'hFFFF);
        rd(5'h1C, v); check("R11", "unmapped offset", v, 0);
        rd(A_MODE, v); check("R11", "mode after unmapped write", v, 0);
        rd(A_CAP, v);  check("R11", "capture reads zero", v, 0);
    endtask

    task automatic t_rate;
        logic [DW-1:0] v;
        arm(1000, 0, mk(0, 0, 1, 1, 1));
        wait_clk(10);
        rd(A_CNT, v); check("R2", "psc=0 after 10 clocks", v, 10);
        arm(1000, 0, mk(3, 0, 1, 1, 1));
        wait_clk(12);
        rd(A_CNT, v); check("R2", "psc=3 after 12 clocks", v, 3);
        wait_clk(3);
        rd(A_CNT, v); check("R2", "psc=3 after 15 clocks", v, 3);
        wait_clk(1);
        rd(A_CNT, v); check("R2", "psc=3 after 16 clocks", v, 4);
        wr(A_CNT, 16'd500);
        rd(A_CNT, v); check("R9", "load while running", v, 500);
    endtask

    task automatic t_slow;
        logic [DW-1:0] v;
        arm(1000, 0, mk(1, 0, 1, 2, 1));
        wait_clk(31);
        rd(A_CNT, v); check("R3", "slow source after 31 clocks", v, 0);
        wait_clk(1);
        rd(A_CNT, v); check("R3", "slow source after 32 clocks", v, 1);
        wait_clk(32);
        rd(A_CNT, v); check("R3", "slow source after 64 clocks", v, 2);
    endtask

    task automatic t_stopped_src;
        logic [DW-1:0] v;
        arm(1000, 7, mk(0, 0, 1, 0, 1));
        wait_clk(20);
        rd(A_CNT, v); check("R4", "source 0 holds", v, 7);
        arm(1000, 7, mk(0, 0, 1, 3, 1));
        wait_clk(20);
        rd(A_CNT, v); check("R4", "source 3 holds", v, 7);
        arm(1000, 7, mk(0, 0, 0, 1, 1));
        wait_clk(20);
        rd(A_CNT, v); check("R4", "restart bit clear holds", v, 7);
    endtask

    task automatic t_wrap;
        logic [DW-1:0] v;
        arm(4, 0, mk(0, 0, 1, 1, 1));
        wait_clk(4);
        rd(A_CNT, v); check("R6", "count at reference", v, 4);
        rd(A_EVT, v); check("R6", "no event before wrap", v, 0);
        wait_clk(1);
        rd(A_CNT, v); check("R6", "count wrapped", v, 0);
        rd(A_EVT, v); check("R6", "event bit 1 set", v, 16'h0002);
        check("R7", "irq low with enable off", DW'(irq), 0);
        wait_clk(4);
        rd(A_CNT, v); check("R6", "second period", v, 4);
    endtask

    task automatic t_irq;
        logic [DW-1:0] v;
        arm(1, 0, mk(9, 0, 1, 1, 1));
        wait_clk(20);
        rd(A_EVT, v); check("R6", "event after psc=9 wrap", v, 16'h0002);
        check("R7", "irq low, enable off", DW'(irq), 0);
        wr(A_MODE, mk(9, 1, 1, 1, 1));
        check("R7", "irq high once enabled", DW'(irq), 1);
        wr(A_EVT, 16'h0000);
        rd(A_EVT, v); check("R8", "write 0 keeps event", v, 16'h0002);
        check("R8", "irq kept after write 0", DW'(irq), 1);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); check("R8", "write 1 clears event", v, 0);
        check("R8", "irq dropped", DW'(irq), 0);
        wait_clk(20);
        check("R7", "irq after next wrap", DW'(irq), 1);
        wr(A_MODE, mk(9, 1, 1, 1, 0));
        rd(A_REF, v);  check("R5", "disable clears reference", v, 0);
        rd(A_CNT, v);  check("R5", "disable clears count", v, 0);
        rd(A_EVT, v);  check("R5", "disable clears event", v, 0);
        rd(A_MODE, v); check("R5", "mode keeps written value", v, mk(9, 1, 1, 1, 0));
        check("R5", "irq low after disable", DW'(irq), 0);
    endtask

    task automatic t_restart;
        logic [DW-1:0] v;
        arm(1000, 0, mk(3, 0, 1, 1, 1));
        wait_clk(2);
        wr(A_REF, 16'd1000);
        wait_clk(3);
        rd(A_CNT, v); check("R10", "phase restarted by reference write", v, 0);
        wait_clk(1);
        rd(A_CNT, v); check("R10", "first tick after restart", v, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_load_stopped();
        t_rate();
        t_slow();
        t_stopped_src();
        t_wrap();
        t_irq();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(5 * 50000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule